// File: doc/BRIEF.md
# Counting Set-Membership Filter with Pinned Saturation

The block keeps a compact, approximate summary of a set of block addresses. Software-invisible control logic inserts an address when a block spills out of local storage and deletes it when the block is reclaimed. Before any expensive table search, it asks whether an address might be in the set. The answer "absent" is always exact. The answer "present" may be a false alarm, which the caller then resolves by a full search elsewhere.

Each address selects `NUM_HASH` counter slots through modular linear hashes. An insert raises each selected counter by one and a delete lowers each by one. Beside the counters sits a one-bit-per-slot map that records which slots are non-zero. Membership queries read only that map and answer in a single cycle.

Counters are `CNT_W` bits wide. A counter that would pass its top value is held there and a sticky overflow-pending flag is raised, so a count never wraps. A held counter is never lowered again, which keeps the filter free of false negatives. Inserts and deletes walk the hashes one per cycle, and the request port is closed (busy) for the whole walk. The map for all touched slots is refreshed on the final step of the walk, together with the last counter write.

Top module: `cbf_filter`

## Requirements
- R1: After reset, busy, rsp_valid, rsp_hit, ovf_pending and underflow_err are 0, and every counter is zero, so every query misses.
- R2: Request codes on req_op are 2'b00 idle, 2'b01 insert, 2'b10 delete and 2'b11 query. Hash lane i (i = 0 .. NUM_HASH-1) selects slot ((8*i+5)*addr + 16*i+7) mod NUM_CNT.
- R3: An accepted insert raises the counter of every hash lane by one, in lane order. Two lanes that select the same slot raise it twice.
- R4: A query accepted at a clock edge drives rsp_valid high for exactly the next cycle. In that cycle rsp_hit is 1 exactly when every slot selected by the address is non-zero. There are no false negatives.
- R5: An accepted delete lowers the counter of every hash lane by one, in lane order. Once all counters of a slot return to zero, queries that need that slot miss.
- R6: After an insert or delete is accepted, busy is high for exactly NUM_HASH cycles. Any request presented while busy is high is ignored: it gives no response and changes no counter.
- R7: An insert that meets a counter already at its top value (15 for 4-bit counters) leaves it there and sets ovf_pending. ovf_pending then stays set until reset.
- R8: A counter at its top value is not lowered by a delete, so the address stays a member.
- R9: A delete that meets a zero counter leaves it at zero and sets underflow_err. underflow_err then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request code (idle, insert, delete, query) |
| req_addr | input | ADDR_W | Block address of the request |
| busy | output | 1 | Insert or delete walk in progress; requests ignored |
| rsp_valid | output | 1 | Query result valid |
| rsp_hit | output | 1 | Query result: possibly present |
| ovf_pending | output | 1 | Sticky: a counter increment was held at the top value |
| underflow_err | output | 1 | Sticky: a delete met a zero counter |

## Verification
A query result is due one cycle after the edge that accepts it. The bench samples it on the falling edge that follows that acceptance edge and compares it against a queue of expected results, filled from a reference model at the moment of issue. After an insert or delete, the bench counts the falling edges on which busy is high and expects exactly NUM_HASH of them. It compares both sticky flags with the model only once busy has dropped, because the last counter write and the map refresh land on the final step of the walk. Requests presented during a walk are checked for silence on the following cycle, and for leaving no trace in later query results.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'b00,
      OP_INSERT = 2'b01,
      OP_DELETE = 2'b10,
      OP_QUERY  = 2'b11
   } cbf_op_e;

   // Multiplier of hash lane i (odd, distinct per lane)
   function automatic int unsigned lane_mult(input int unsigned lane);
      return 8 * lane + 5;
   endfunction

   // Offset of hash lane i
   function automatic int unsigned lane_offs(input int unsigned lane);
      return 16 * lane + 7;
   endfunction

endpackage

// File: rtl/cbf_hash.sv
module cbf_hash #(
   parameter int ADDR_W   = 16,
   parameter int NUM_CNT  = 61,
   parameter int NUM_HASH = 4,
   localparam int IDX_W   = $clog2(NUM_CNT),
   localparam int PROD_W  = ADDR_W + 8
) (
   input  logic [ADDR_W-1:0]                  addr,
   output logic [NUM_HASH-1:0][IDX_W-1:0]     slot
);

   for (genvar g = 0; g < NUM_HASH; g++) begin : g_lane
      localparam logic [PROD_W-1:0] MULT = PROD_W'(cbf_pkg::lane_mult(g));
      localparam logic [PROD_W-1:0] OFFS = PROD_W'(cbf_pkg::lane_offs(g));
      localparam logic [PROD_W-1:0] MODN = PROD_W'(NUM_CNT);
      logic [PROD_W-1:0] lin;
      assign lin     = MULT * PROD_W'(addr) + OFFS;
      assign slot[g] = IDX_W'(lin % MODN);
   end

endmodule

// File: rtl/cbf_counter_bank.sv
module cbf_counter_bank #(
   parameter int NUM_CNT = 61,
   parameter int CNT_W   = 4,
   localparam int IDX_W  = $clog2(NUM_CNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_en,
   input  logic               upd_add,
   input  logic [IDX_W-1:0]   upd_slot,
   output logic               new_nz,
   output logic               sat_evt,
   output logic               unf_evt,
   output logic [NUM_CNT-1:0] cnt_nz
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] cnt_q [NUM_CNT];
   logic [CNT_W-1:0] old_val;
   logic [CNT_W-1:0] new_val;
   logic             at_top;
   logic             at_zero;

   assign old_val = cnt_q[upd_slot];
   assign at_top  = (old_val == CNT_TOP);
   assign at_zero = (old_val == '0);

   always_comb begin
      if (upd_add) begin
         new_val = at_top ? old_val : old_val + CNT_W'(1);
      end else begin
         new_val = (at_top || at_zero) ? old_val : old_val - CNT_W'(1);
      end
   end

   assign new_nz  = (new_val != '0);
   assign sat_evt = upd_en &&  upd_add && at_top;
   assign unf_evt = upd_en && !upd_add && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CNT; i++) begin
            cnt_q[i] <= '0;
         end
      end else if (upd_en) begin
         cnt_q[upd_slot] <= new_val;
      end
   end

   for (genvar c = 0; c < NUM_CNT; c++) begin : g_nz
      assign cnt_nz[c] = (cnt_q[c] != '0);
   end

endmodule

// File: rtl/cbf_nz_map.sv
module cbf_nz_map #(
   parameter int NUM_CNT  = 61,
   parameter int NUM_HASH = 4,
   localparam int IDX_W   = $clog2(NUM_CNT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit,
   input  logic [NUM_HASH-1:0][IDX_W-1:0] touched,
   input  logic [IDX_W-1:0]              cur_slot,
   input  logic                          cur_nz,
   input  logic [NUM_CNT-1:0]            cnt_nz,
   input  logic [NUM_HASH-1:0][IDX_W-1:0] probe,
   output logic                          hit
);

   logic [NUM_CNT-1:0] map_q;
   logic [NUM_HASH-1:0] lane_set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (commit) begin
         for (int i = 0; i < NUM_HASH; i++) begin
            if (touched[i] == cur_slot) begin
               map_q[touched[i]] <= cur_nz;
            end else begin
               map_q[touched[i]] <= cnt_nz[touched[i]];
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_HASH; g++) begin : g_probe
      assign lane_set[g] = map_q[probe[g]];
   end

   assign hit = &lane_set;

endmodule

// File: rtl/cbf_seq.sv
module cbf_seq #(
   parameter int ADDR_W   = 16,
   parameter int NUM_HASH = 4,
   localparam int STEP_W  = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              upd_add,
   output logic [STEP_W-1:0] step,
   output logic [ADDR_W-1:0] upd_addr,
   output logic              commit,
   output logic              query_fire
);

   import cbf_pkg::*;

   cbf_op_e           op_in;
   logic              accept;
   logic              start_upd;
   logic              last_step;
   logic              busy_q;
   logic              add_q;
   logic [STEP_W-1:0] step_q;
   logic [ADDR_W-1:0] addr_q;

   assign op_in      = cbf_op_e'(req_op);
   assign accept     = req_valid && !busy_q && (op_in != OP_IDLE);
   assign start_upd  = accept && ((op_in == OP_INSERT) || (op_in == OP_DELETE));
   assign query_fire = accept && (op_in == OP_QUERY);
   assign last_step  = (step_q == STEP_W'(NUM_HASH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         add_q  <= 1'b0;
         step_q <= '0;
         addr_q <= '0;
      end else if (start_upd) begin
         busy_q <= 1'b1;
         add_q  <= (op_in == OP_INSERT);
         step_q <= '0;
         addr_q <= req_addr;
      end else if (busy_q) begin
         if (last_step) begin
            busy_q <= 1'b0;
            step_q <= '0;
         end else begin
            step_q <= step_q + STEP_W'(1);
         end
      end
   end

   assign busy     = busy_q;
   assign upd_add  = add_q;
   assign step     = step_q;
   assign upd_addr = addr_q;
   assign commit   = busy_q && last_step;

endmodule

// File: rtl/cbf_filter.sv
module cbf_filter #(
   parameter int ADDR_W   = 16,
   parameter int NUM_CNT  = 61,
   parameter int CNT_W    = 4,
   parameter int NUM_HASH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              ovf_pending,
   output logic              underflow_err
);

   localparam int IDX_W  = $clog2(NUM_CNT);
   localparam int STEP_W = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1;

   if (!((NUM_HASH == 2) || (NUM_HASH == 4))) begin : g_bad_hash
      $error("cbf_filter: NUM_HASH must be 2 or 4");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("cbf_filter: CNT_W must be at least 2");
   end
   if (NUM_CNT < 2 * NUM_HASH) begin : g_bad_depth
      $error("cbf_filter: NUM_CNT too small for NUM_HASH");
   end

   logic                           upd_add;
   logic [STEP_W-1:0]              step;
   logic [ADDR_W-1:0]              upd_addr;
   logic                           commit;
   logic                           query_fire;
   logic [NUM_HASH-1:0][IDX_W-1:0] upd_slots;
   logic [NUM_HASH-1:0][IDX_W-1:0] req_slots;
   logic [IDX_W-1:0]               cur_slot;
   logic                           new_nz;
   logic                           sat_evt;
   logic                           unf_evt;
   logic [NUM_CNT-1:0]             cnt_nz;
   logic                           map_hit;
   logic                           rsp_valid_q;
   logic                           rsp_hit_q;
   logic                           ovf_q;
   logic                           unf_q;

   cbf_seq #(.ADDR_W(ADDR_W), .NUM_HASH(NUM_HASH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_addr   (req_addr),
      .busy       (busy),
      .upd_add    (upd_add),
      .step       (step),
      .upd_addr   (upd_addr),
      .commit     (commit),
      .query_fire (query_fire)
   );

   cbf_hash #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .NUM_HASH(NUM_HASH)) u_hash_upd (
      .addr (upd_addr),
      .slot (upd_slots)
   );

   cbf_hash #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .NUM_HASH(NUM_HASH)) u_hash_req (
      .addr (req_addr),
      .slot (req_slots)
   );

   assign cur_slot = upd_slots[step];

   cbf_counter_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (busy),
      .upd_add  (upd_add),
      .upd_slot (cur_slot),
      .new_nz   (new_nz),
      .sat_evt  (sat_evt),
      .unf_evt  (unf_evt),
      .cnt_nz   (cnt_nz)
   );

   cbf_nz_map #(.NUM_CNT(NUM_CNT), .NUM_HASH(NUM_HASH)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .touched  (upd_slots),
      .cur_slot (cur_slot),
      .cur_nz   (new_nz),
      .cnt_nz   (cnt_nz),
      .probe    (req_slots),
      .hit      (map_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         ovf_q       <= 1'b0;
         unf_q       <= 1'b0;
      end else begin
         rsp_valid_q <= query_fire;
         rsp_hit_q   <= query_fire && map_hit;
         ovf_q       <= ovf_q || sat_evt;
         unf_q       <= unf_q || unf_evt;
      end
   end

   assign rsp_valid     = rsp_valid_q;
   assign rsp_hit       = rsp_hit_q;
   assign ovf_pending   = ovf_q;
   assign underflow_err = unf_q;

endmodule

// File: rtl/cbf_filter_chk.sv
module cbf_filter_chk #(
   parameter int NUM_HASH = 4,
   localparam int RUN_W   = $clog2(NUM_HASH) + 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_op,
   input logic       busy,
   input logic       rsp_valid,
   input logic       ovf_pending,
   input logic       underflow_err
);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (busy) begin
         run_q <= run_q + RUN_W'(1);
      end else begin
         run_q <= '0;
      end
   end

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run_q != '0) |-> (run_q == RUN_W'(NUM_HASH)));

   // R6
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && (req_op == 2'b01 || req_op == 2'b10)));

   // R4
   rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_op == 2'b11 && !busy));

   // R4
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pending |=> ovf_pending);

   // R9
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_err |=> underflow_err);

endmodule

bind cbf_filter cbf_filter_chk #(.NUM_HASH(NUM_HASH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_op        (req_op),
   .busy          (busy),
   .rsp_valid     (rsp_valid),
   .ovf_pending   (ovf_pending),
   .underflow_err (underflow_err)
);

// File: tb/cbf_filter_bench.sv
module cbf_filter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;
   localparam int NUM_CNT    = 61;
   localparam int NUM_HASH   = 4;
   localparam int CNT_TOP    = 15;

   logic              clk;
   logic              rst_n;
   logic              req_valid;
   logic [1:0]        req_op;
   logic [ADDR_W-1:0] req_addr;
   logic              busy;
   logic              rsp_valid;
   logic              rsp_hit;
   logic              ovf_pending;
   logic              underflow_err;

   cbf_filter #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .CNT_W(4), .NUM_HASH(NUM_HASH)) u_cbf_filter (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_op        (req_op),
      .req_addr      (req_addr),
      .busy          (busy),
      .rsp_valid     (rsp_valid),
      .rsp_hit       (rsp_hit),
      .ovf_pending   (ovf_pending),
      .underflow_err (underflow_err)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   int mdl_cnt [NUM_CNT];
   bit mdl_ovf = 1'b0;
   bit mdl_unf = 1'b0;
   bit exp_q [$];

   function automatic int slot_of(input int lane, input int a);
      return ((8 * lane + 5) * a + 16 * lane + 7) % NUM_CNT;
   endfunction

   function automatic bit mdl_member(input int a);
      for (int i = 0; i < NUM_HASH; i++) begin
         if (mdl_cnt[slot_of(i, a)] == 0) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic void mdl_apply(input logic [1:0] op, input int a);
      for (int i = 0; i < NUM_HASH; i++) begin
         int s = slot_of(i, a);
         if (op == 2'b01) begin
            if (mdl_cnt[s] == CNT_TOP) mdl_ovf = 1'b1;
            else mdl_cnt[s]++;
         end else begin
            if (mdl_cnt[s] == 0) mdl_unf = 1'b1;
            else if (mdl_cnt[s] != CNT_TOP) mdl_cnt[s]--;
         end
      end
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected result for each response seen
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R6 unexpected response: actual 1 expected 0");
         end else begin
            bit e;
            e = exp_q.pop_front();
            chk("R2/R4 query result", int'(rsp_hit), int'(e));
         end
      end
   end

   // Driver: one request, expected results pushed at issue time
   task automatic issue(input logic [1:0] op, input int a);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_addr  = a[ADDR_W-1:0];
      if (op == 2'b11) exp_q.push_back(mdl_member(a));
      else mdl_apply(op, a);
      @(negedge clk);
      req_valid = 1'b0;
      req_op    = 2'b00;
      if (op != 2'b11) begin
         int n = 0;
         while (busy) begin
            n++;
            @(negedge clk);
         end
         chk("R6 busy length", n, NUM_HASH);
         chk("R7 ovf_pending", int'(ovf_pending), int'(mdl_ovf));
         chk("R9 underflow_err", int'(underflow_err), int'(mdl_unf));
      end
   endtask

   // Requests presented during a walk must be ignored
   task automatic busy_probe(input int a_ins, input int a_q, input int a_late);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1;
      req_op    = 2'b01;
      req_addr  = a_ins[ADDR_W-1:0];
      mdl_apply(2'b01, a_ins);
      @(negedge clk);
      req_op    = 2'b11;
      req_addr  = a_q[ADDR_W-1:0];
      @(negedge clk);
      chk("R6 query during busy ignored", int'(rsp_valid), 0);
      req_op    = 2'b01;
      req_addr  = a_late[ADDR_W-1:0];
      @(negedge clk);
      req_valid = 1'b0;
      req_op    = 2'b00;
      while (busy) @(negedge clk);
   endtask

   task automatic run_all();
      for (int i = 0; i < NUM_CNT; i++) mdl_cnt[i] = 0;
      req_valid = 1'b0;
      req_op    = 2'b00;
      req_addr  = '0;
      rst_n     = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
      chk("R1 rsp_hit after reset", int'(rsp_hit), 0);
      chk("R1 ovf_pending after reset", int'(ovf_pending), 0);
      chk("R1 underflow_err after reset", int'(underflow_err), 0);
      issue(2'b11, 100);
      issue(2'b11, 2000);
      // R9: delete from an empty filter
      issue(2'b10, 777);
      chk("R9 underflow raised", int'(underflow_err), 1);
      issue(2'b11, 777);
      // R3: inserts, then queries must hit
      issue(2'b01, 'h1234);
      issue(2'b01, 'h0042);
      issue(2'b01, 'hBEEF);
      issue(2'b11, 'h1234);
      issue(2'b11, 'h0042);
      issue(2'b11, 'hBEEF);
      issue(2'b11, 'h5555);
      // R5: delete one of them
      issue(2'b10, 'h0042);
      issue(2'b11, 'h0042);
      issue(2'b11, 'h1234);
      // R6: requests during a walk
      busy_probe('h0101, 'h0202, 'h0303);
      issue(2'b11, 'h0303);
      issue(2'b11, 'h0101);
      // R7: drive one address past the counter top
      chk("R7 no overflow yet", int'(ovf_pending), 0);
      for (int r = 0; r < CNT_TOP + 1; r++) issue(2'b01, 'hA5A5);
      chk("R7 overflow raised", int'(ovf_pending), 1);
      issue(2'b11, 'hA5A5);
      // R8: pinned counters survive deletes
      for (int r = 0; r < CNT_TOP + 1; r++) issue(2'b10, 'hA5A5);
      issue(2'b11, 'hA5A5);
      repeat (3) @(negedge clk);
      chk("R4 outstanding results", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (50000) @(posedge clk);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule